// File: doc/BRIEF.md
# Dual-Lane Ones-Complement Running-Sum Accumulator

This block adds up a stream of 32-bit words as two separate 16-bit ones-complement totals. One total covers the upper half of every word and the other covers the lower half. It is meant to sit beside a data mover. Each word that crosses the bus can be folded into the totals at a rate of one word per clock. Producing a final network checksum from the two totals is left to the consumer: that step adds the halves together and inverts the result.

Each 16-bit lane is split into six small adder groups with full lookahead. The groups cover bits 1:0, 4:2, 7:5, 9:8, 12:10 and 15:13. Each group's carry-out is registered and enters the next group up on the following clock. The carry from the top group re-enters at bit 0, so the carry path is a ring. Carries are therefore deferred. On any clock without an add, zero is accumulated so that carries still in flight can drain. After the last add, a few idle clocks must pass before the total settles.

A clear input zeroes the totals, the carry ring and the held input word. There is no load operation: a start value is added as an ordinary word just after a clear. A capture strobe stores the bus word, and the add enable accumulates it. When the strobe and the add enable are high together, the word on the bus that cycle is added directly.

Top module: `ocsum_ring_acc`

## Requirements
- R1: After a synchronous reset (`rst` high), with `oe` high, `bus_q` reads 0x00000000.
- R2: `bus_q[31:16]` and `bus_q[15:0]` are independent 16-bit totals. An overflow of the lower lane never changes the upper lane, and the reverse also holds.
- R3: Once `add_en` has been low for 12 clocks, each lane equals the 16-bit ones-complement end-around-carry sum of that lane's added half-words since the last clear.
- R4: With the accumulator and carries at zero, a word added at a clock edge appears unchanged on `bus_q` right after that edge.
- R5: A clock with `add_en` low accumulates zero. A settled total stays unchanged across idle clocks.
- R6: `clr` zeroes both totals, all carry registers and the held word at the next edge, and it overrides `add_en` in the same cycle.
- R7: Words added on consecutive clocks with no gaps give the same settled totals as words added with idle clocks between them.
- R8: When `latch_en` is high, `din` is stored. `add_en` with `latch_en` high adds the current `din`; `add_en` with `latch_en` low adds the stored word. `latch_en` alone leaves the totals unchanged.
- R9: `bus_oe` follows `oe`. `bus_q` carries the totals (upper lane in bits 31:16) when `oe` is high and reads all zeros when `oe` is low.
- R10: After a clear, a start value can be preset by adding it as the first word, and later words build on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the accumulation pipeline |
| rst | input | 1 | Synchronous active-high reset, same effect as clr |
| clr | input | 1 | Zero totals, carry ring and held word |
| latch_en | input | 1 | Capture `din` into the held word |
| add_en | input | 1 | Accumulate the selected word this clock |
| oe | input | 1 | Present the totals on `bus_q` |
| din | input | 32 | Data word from the bus |
| bus_q | output | 32 | Totals (upper lane 31:16, lower lane 15:0), zero when not enabled |
| bus_oe | output | 1 | Drive enable for an external tri-state pad |

## Verification
Several properties are checked on every cycle. A clear empties each lane's total and carry ring at the next edge. An idle cycle with no carries in flight leaves a lane's total untouched. A word added to an empty lane lands exactly at the next edge. The held word keeps its value unless it is strobed or cleared. Only the bench scenarios can show that the deferred carries, once drained, reproduce the end-around-carry sum. They also show that the lanes stay isolated under overflow, that bursts and spaced adds agree, and that the strobe and add-enable combinations select the right word.

// File: rtl/ocr_pkg.sv
package ocr_pkg;

    localparam int HALF_W = 16;
    localparam int NGRP   = 6;
    localparam int LANES  = 2;
    localparam int DATA_W = LANES * HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0] sum;
        logic [NGRP-1:0]   cry;
    } lane_state_t;

    function automatic int grp_lo(input int k);
        case (k)
            0: return 0;
            1: return 2;
            2: return 5;
            3: return 8;
            4: return 10;
            default: return 13;
        endcase
    endfunction

    function automatic int grp_w(input int k);
        case (k)
            0: return 2;
            1: return 3;
            2: return 3;
            3: return 2;
            4: return 3;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/ocr_input_hold.sv
module ocr_input_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         latch_en,
    input  logic         add_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] operand
);
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            hold_q <= '0;
        else if (latch_en)
            hold_q <= din;
    end

    always_comb begin
        if (!add_en || clr)
            operand = '0;
        else if (latch_en)
            operand = din;
        else
            operand = hold_q;
    end

    // R8: the held word keeps its value without a strobe or clear
    p_hold_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr && !latch_en) |=> $stable(hold_q));

endmodule

// File: rtl/ocr_la_group.sv
module ocr_la_group #(
    parameter int W = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W-1:0] gen, prop;
    logic [W:0]   c;

    always_comb begin
        gen  = a & b;
        prop = a ^ b;
        c[0] = cin;
        for (int i = 0; i < W; i++)
            c[i+1] = gen[i] | (prop[i] & c[i]);
        s    = prop ^ c[W-1:0];
        cout = c[W];
    end

endmodule

// File: rtl/ocr_ring_lane.sv
module ocr_ring_lane
    import ocr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [HALF_W-1:0] operand,
    output logic [HALF_W-1:0] sum_q
);
    lane_state_t st_q, st_d;
    logic [NGRP-1:0] cin_v;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        localparam int LO = grp_lo(k);
        localparam int GW = grp_w(k);
        if (k == 0) begin : g_wrap
            assign cin_v[k] = st_q.cry[NGRP-1];
        end else begin : g_chain
            assign cin_v[k] = st_q.cry[k-1];
        end
        ocr_la_group #(.W(GW)) u_grp (
            .a    (st_q.sum[LO +: GW]),
            .b    (operand[LO +: GW]),
            .cin  (cin_v[k]),
            .s    (st_d.sum[LO +: GW]),
            .cout (st_d.cry[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign sum_q = st_q.sum;

    // R6: clear empties total and carry ring at the next edge
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st_q.sum == '0 && st_q.cry == '0));

    // R5: idle with no carries in flight leaves the total untouched
    p_idle_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && operand == '0 && st_q.cry == '0) |=> ($stable(st_q.sum) && st_q.cry == '0));

    // R4: a word added to an empty lane lands exactly
    p_fresh_add_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && st_q.sum == '0 && st_q.cry == '0) |=> (st_q.sum == $past(operand)));

endmodule

// File: rtl/ocsum_ring_acc.sv
module ocsum_ring_acc
    import ocr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              latch_en,
    input  logic              add_en,
    input  logic              oe,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] bus_q,
    output logic              bus_oe
);
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] totals;

    ocr_input_hold #(.W(DATA_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .latch_en (latch_en),
        .add_en   (add_en),
        .din      (din),
        .operand  (operand)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ocr_ring_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .operand (operand[l*HALF_W +: HALF_W]),
            .sum_q   (totals[l*HALF_W +: HALF_W])
        );
    end

    assign bus_q  = oe ? totals : '0;
    assign bus_oe = oe;

endmodule

// File: tb/ocsum_ring_acc_test.sv
module ocsum_ring_acc_test;
    localparam int CLK_P = 10;
    localparam int NV = 8;
    localparam logic [31:0] VEC [NV] = '{
        32'h1234_ABCD, 32'hFFFF_0001, 32'h8000_FFFE, 32'h0001_7FFF,
        32'hEDCB_5432, 32'hFFFF_FFFF, 32'h0F0F_F0F0, 32'hAAAA_5555
    };

    logic clk = 0, rst = 1, clr = 0, latch_en = 0, add_en = 0, oe = 1;
    logic [31:0] din = 0;
    logic [31:0] bus_q;
    logic bus_oe;
    int n_chk = 0, n_fail = 0;
    logic [15:0] ref_hi, ref_lo;

    always #(CLK_P/2) clk = ~clk;

    ocsum_ring_acc uut (.clk(clk), .rst(rst), .clr(clr), .latch_en(latch_en),
        .add_en(add_en), .oe(oe), .din(din), .bus_q(bus_q), .bus_oe(bus_oe));

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] r;
        r = {1'b0, a} + {1'b0, b};
        return r[15:0] + {15'd0, r[16]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic add_word(input logic [31:0] w);
        din = w; latch_en = 1; add_en = 1;
        @(negedge clk);
        latch_en = 0; add_en = 0;
        ref_hi = oc_add(ref_hi, w[31:16]);
        ref_lo = oc_add(ref_lo, w[15:0]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear();
        clr = 1; @(negedge clk); clr = 0;
        ref_hi = 0; ref_lo = 0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        ref_hi = 0; ref_lo = 0;
        idle(3);
        rst = 0;
        idle(1);
        check("R1 reset", bus_q, 32'h0);

        // R3 table walk, settled comparison after each word
        for (int i = 0; i < NV; i++) begin
            add_word(VEC[i]);
            idle(12);
            check("R3 settled sum", bus_q, {ref_hi, ref_lo});
        end
        // R5 settled value stays put
        idle(20);
        check("R5 idle hold", bus_q, {ref_hi, ref_lo});

        // R9 output enable low
        oe = 0; idle(1);
        check("R9 bus released", {bus_q[31:1], bus_oe}, 32'h0);
        oe = 1; idle(1);
        check("R9 bus driven", {bus_oe, bus_q[30:0]}, {1'b1, ref_lo == ref_lo ? {ref_hi[14:0], ref_lo} : 31'h0});

        // R6 clear
        do_clear();
        check("R6 clear", bus_q, 32'h0);

        // R4 single word lands at next edge
        add_word(32'hBEEF_1357);
        check("R4 fresh add", bus_q, 32'hBEEF_1357);

        // R2 lane isolation: low lane overflows, high stays
        do_clear();
        add_word(32'h0000_FFFF);
        add_word(32'h0000_0002);
        idle(12);
        check("R2 low overflow isolated", bus_q, {ref_hi, ref_lo});
        check("R2 high lane zero", {16'h0, bus_q[31:16]}, 32'h0);
        do_clear();
        add_word(32'hFFFF_0000);
        add_word(32'h0003_0000);
        idle(12);
        check("R2 high overflow isolated", bus_q, {ref_hi, ref_lo});

        // R7 burst of back-to-back words
        do_clear();
        din = VEC[0]; latch_en = 1; add_en = 1;
        for (int i = 0; i < NV; i++) begin
            din = VEC[i];
            ref_hi = oc_add(ref_hi, VEC[i][31:16]);
            ref_lo = oc_add(ref_lo, VEC[i][15:0]);
            @(negedge clk);
        end
        latch_en = 0; add_en = 0;
        idle(12);
        check("R7 burst sum", bus_q, {ref_hi, ref_lo});

        // R8 strobe alone changes nothing
        do_clear();
        din = 32'h5A5A_3C3C; latch_en = 1; @(negedge clk); latch_en = 0;
        din = 32'h0;
        idle(2);
        check("R8 strobe only", bus_q, 32'h0);
        // R8 add without strobe uses the held word
        add_en = 1; @(negedge clk); add_en = 0;
        check("R8 held word added", bus_q, 32'h5A5A_3C3C);
        ref_hi = 16'h5A5A; ref_lo = 16'h3C3C;
        add_en = 1; @(negedge clk); add_en = 0;
        ref_hi = oc_add(ref_hi, 16'h5A5A); ref_lo = oc_add(ref_lo, 16'h3C3C);
        idle(12);
        check("R8 held word again", bus_q, {ref_hi, ref_lo});

        // R6 clear beats add, and clears held word
        clr = 1; add_en = 1; latch_en = 1; din = 32'h1111_2222;
        @(negedge clk);
        clr = 0; add_en = 0; latch_en = 0;
        ref_hi = 0; ref_lo = 0;
        check("R6 clear priority", bus_q, 32'h0);
        add_en = 1; @(negedge clk); add_en = 0;
        idle(12);
        check("R6 held word cleared", bus_q, 32'h0);

        // R10 preset value then data
        do_clear();
        add_word(32'hF000_8001);
        add_word(32'h1234_8000);
        add_word(32'h0FFF_FFFF);
        idle(12);
        check("R10 preset then data", bus_q, {ref_hi, ref_lo});

        // R1 reset after activity
        rst = 1; idle(1); rst = 0;
        check("R1 reset after use", bus_q, 32'h0);

        report();
    end
endmodule